// File: doc/BRIEF.md
# Paged Program Counter Sequencer

This block owns the 13-bit fetch address of a small accumulator machine that overlaps fetch and execute in two stages. Each cycle the address normally moves on by one. The execute stage can ask for two kinds of redirect: an unconditional jump, which supplies an 11-bit target, and a skip. The two missing high address bits of a jump come from a separate page register. When either redirect is accepted, the instruction already fetched behind the current one must not take effect, so the block raises a one-cycle flush that turns that instruction into a no-operation.

The execute unit drives `jump_i` and `skip_i` for the instruction it holds in the current cycle. The block answers with the address to fetch next and with `flush_o`, which marks the instruction now in execute as discarded. A discarded instruction can neither jump nor skip. Together, the flush and the sequencing give the timing: a jump or a taken skip costs two cycles, and every other instruction costs one.

Top module: `pcs_pc_sequencer`

## Requirements
- R1: After an accepted jump, bits 10:0 of `fetch_addr_o` equal the `target_i` value sampled at that edge.
- R2: After an accepted jump, bits 12:11 of `fetch_addr_o` equal bits 4:3 of the `page_i` value sampled at that edge.
- R3: With no accepted jump, `fetch_addr_o` increases by one each cycle and wraps from 0x1FFF to 0x0000.
- R4: An accepted jump makes `flush_o` high in the next cycle only, so the jump occupies two cycles.
- R5: An accepted skip makes `flush_o` high in the next cycle only, and the fetch address still advances by one.
- R6: When neither a jump nor a skip is requested, `flush_o` is low in the next cycle and the instruction occupies one cycle.
- R7: A jump or skip request made while `flush_o` is high is ignored: the address advances by one and `flush_o` is low in the next cycle.
- R8: When a jump and a skip are requested together in a valid slot, the jump takes precedence and only one flush cycle follows.
- R9: A synchronous reset sets `fetch_addr_o` to 0x0000 and `flush_o` low, so the first slot after reset is valid.
- R10: The bits of `page_i` other than 4:3 have no effect on the fetch address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| jump_i | input | 1 | Execute stage holds an unconditional jump |
| target_i | input | 11 | Low address bits of the jump destination |
| page_i | input | 8 | Page register contents; bits 4:3 give the high address bits |
| skip_i | input | 1 | Execute stage requests skipping the next instruction |
| fetch_addr_o | output | 13 | Address of the instruction being fetched |
| flush_o | output | 1 | Instruction now in execute is discarded and runs as a no-operation |

## Verification
A jump and a skip can be raised in the same cycle, and a redirect request can arrive in a slot that is already flushed. The bench raises both requests together with a distinct target and page, and raises requests in the cycle right after a jump or skip. A reference model in the scoreboard predicts the address and the flush state for every vector. The result is judged by whether the next address is the jump destination and not an advance by one, whether exactly one flush cycle follows, and whether a request in a flushed slot leaves the sequence unchanged.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  // Kind of redirect accepted for the instruction in execute this cycle.
  typedef enum logic [1:0] {
    REDIR_NONE = 2'd0,
    REDIR_SKIP = 2'd1,
    REDIR_JUMP = 2'd2
  } redir_e;
endpackage

// File: rtl/pcs_redirect.sv
module pcs_redirect
  import pcs_pkg::*;
#(
  parameter int PC_W    = 13,
  parameter int TGT_W   = 11,
  parameter int LATCH_W = 8,
  parameter int PAGE_LO = 3
) (
  input  logic               slot_flushed,
  input  logic               jump_req,
  input  logic               skip_req,
  input  logic [TGT_W-1:0]   target,
  input  logic [LATCH_W-1:0] page_latch,
  output redir_e             kind,
  output logic               jump_taken,
  output logic               skip_taken,
  output logic [PC_W-1:0]    jump_dest
);
  localparam int PAGE_W = PC_W - TGT_W;

  // Destination: page field on top, immediate target below.
  function automatic logic [PC_W-1:0] build_dest(input logic [TGT_W-1:0] tgt,
                                                 input logic [LATCH_W-1:0] latch);
    return {latch[PAGE_LO +: PAGE_W], tgt};
  endfunction

  logic unused_latch_bits;
  assign unused_latch_bits = ^page_latch;

  // A discarded slot cannot redirect; a jump outranks a skip.
  assign jump_taken = jump_req && !slot_flushed;
  assign skip_taken = skip_req && !slot_flushed && !jump_req;
  assign jump_dest  = build_dest(target, page_latch);

  always_comb begin
    kind = REDIR_NONE;
    if (jump_taken)      kind = REDIR_JUMP;
    else if (skip_taken) kind = REDIR_SKIP;
  end
endmodule

// File: rtl/pcs_pc_reg.sv
module pcs_pc_reg
  import pcs_pkg::*;
#(
  parameter int PC_W = 13
) (
  input  logic            clk,
  input  logic            rst,
  input  redir_e          kind,
  input  logic [PC_W-1:0] jump_dest,
  output logic [PC_W-1:0] pc_q
);
  function automatic logic [PC_W-1:0] seq_next(input logic [PC_W-1:0] pc);
    return pc + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)                     pc_q <= '0;
    else if (kind == REDIR_JUMP) pc_q <= jump_dest;
    else                         pc_q <= seq_next(pc_q);
  end
endmodule

// File: rtl/pcs_slot_tracker.sv
module pcs_slot_tracker
  import pcs_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  redir_e kind,
  output logic   flush_q
);
  // The instruction fetched this cycle enters execute discarded after any redirect.
  always_ff @(posedge clk) begin
    if (rst) flush_q <= 1'b0;
    else     flush_q <= (kind != REDIR_NONE);
  end
endmodule

// File: rtl/pcs_pc_sequencer.sv
module pcs_pc_sequencer
  import pcs_pkg::*;
#(
  parameter int PC_W    = 13,
  parameter int TGT_W   = 11,
  parameter int LATCH_W = 8,
  parameter int PAGE_LO = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               jump_i,
  input  logic [TGT_W-1:0]   target_i,
  input  logic [LATCH_W-1:0] page_i,
  input  logic               skip_i,
  output logic [PC_W-1:0]    fetch_addr_o,
  output logic               flush_o
);
  redir_e          kind;
  logic            jump_taken;
  logic            skip_taken;
  logic [PC_W-1:0] jump_dest;

  pcs_redirect #(
    .PC_W(PC_W), .TGT_W(TGT_W), .LATCH_W(LATCH_W), .PAGE_LO(PAGE_LO)
  ) redirect_i (
    .slot_flushed(flush_o),
    .jump_req    (jump_i),
    .skip_req    (skip_i),
    .target      (target_i),
    .page_latch  (page_i),
    .kind        (kind),
    .jump_taken  (jump_taken),
    .skip_taken  (skip_taken),
    .jump_dest   (jump_dest)
  );

  pcs_pc_reg #(.PC_W(PC_W)) pc_reg_i (
    .clk      (clk),
    .rst      (rst),
    .kind     (kind),
    .jump_dest(jump_dest),
    .pc_q     (fetch_addr_o)
  );

  pcs_slot_tracker slot_i (
    .clk    (clk),
    .rst    (rst),
    .kind   (kind),
    .flush_q(flush_o)
  );
endmodule

// File: rtl/pcs_pc_sequencer_chk.sv
module pcs_pc_sequencer_chk #(
  parameter int PC_W    = 13,
  parameter int TGT_W   = 11,
  parameter int LATCH_W = 8,
  parameter int PAGE_LO = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               jump_i,
  input logic               skip_i,
  input logic [TGT_W-1:0]   target_i,
  input logic [LATCH_W-1:0] page_i,
  input logic [PC_W-1:0]    fetch_addr_o,
  input logic               flush_o,
  input logic               jump_taken,
  input logic               skip_taken
);
  localparam int PAGE_W = PC_W - TGT_W;

  // R1 and R2 (R10: only the page field reaches the address)
  p_jump_dest_r1: assert property (@(posedge clk) disable iff (rst)
    jump_taken |=> fetch_addr_o == {$past(page_i[PAGE_LO +: PAGE_W]), $past(target_i)});

  p_seq_advance_r3: assert property (@(posedge clk) disable iff (rst)
    !jump_taken |=> fetch_addr_o == PC_W'($past(fetch_addr_o) + 1'b1));

  // R4 and R5
  p_flush_after_redirect_r4: assert property (@(posedge clk) disable iff (rst)
    (jump_taken || skip_taken) |=> flush_o);

  p_no_flush_plain_r6: assert property (@(posedge clk) disable iff (rst)
    !(jump_i || skip_i) |=> !flush_o);

  p_flush_single_r7: assert property (@(posedge clk) disable iff (rst)
    flush_o |=> !flush_o);

  p_jump_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (jump_i && skip_i && !flush_o) |-> (jump_taken && !skip_taken));

  p_reset_state_r9: assert property (@(posedge clk)
    rst |=> (fetch_addr_o == '0) && !flush_o);
endmodule

bind pcs_pc_sequencer pcs_pc_sequencer_chk #(
  .PC_W(PC_W), .TGT_W(TGT_W), .LATCH_W(LATCH_W), .PAGE_LO(PAGE_LO)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .jump_i      (jump_i),
  .skip_i      (skip_i),
  .target_i    (target_i),
  .page_i      (page_i),
  .fetch_addr_o(fetch_addr_o),
  .flush_o     (flush_o),
  .jump_taken  (jump_taken),
  .skip_taken  (skip_taken)
);

// File: tb/pcs_pc_sequencer_tb_top.sv
`timescale 1ns/1ps
module pcs_pc_sequencer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        jump_i = 1'b0;
  logic [10:0] target_i = '0;
  logic [7:0]  page_i = '0;
  logic        skip_i = 1'b0;
  logic [12:0] fetch_addr_o;
  logic        flush_o;

  always #2 clk = ~clk;

  pcs_pc_sequencer dut_i (
    .clk(clk), .rst(rst), .jump_i(jump_i), .target_i(target_i),
    .page_i(page_i), .skip_i(skip_i), .fetch_addr_o(fetch_addr_o), .flush_o(flush_o)
  );

  typedef struct {
    logic [12:0] pc;
    logic        fl;
    string       tag;
  } exp_t;

  exp_t        q[$];
  int          n_vec  = 0;
  int          n_fail = 0;
  logic [12:0] m_pc   = '0;
  logic        m_fl   = 1'b0;
  bit          done   = 1'b0;

  // Driver: applies one cycle of inputs and predicts the state after the edge.
  task automatic step(input bit r, input bit j, input logic [10:0] t,
                      input logic [7:0] p, input bit s, input string tag);
    exp_t e;
    bit   ok;
    @(negedge clk);
    rst = r; jump_i = j; target_i = t; page_i = p; skip_i = s;
    ok = !m_fl;
    if (r) begin
      m_pc = 13'h0000; m_fl = 1'b0;
    end else if (ok && j) begin
      m_pc = {p[4], p[3], t}; m_fl = 1'b1;
    end else begin
      m_pc = m_pc + 13'd1; m_fl = ok && s;
    end
    e.pc = m_pc; e.fl = m_fl; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compares after every edge that has a prediction pending.
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_vec++;
      if (fetch_addr_o !== e.pc || flush_o !== e.fl) begin
        n_fail++;
        $display("FAIL %s: addr=%h flush=%b expected addr=%h flush=%b",
                 e.tag, fetch_addr_o, flush_o, e.pc, e.fl);
      end
    end
  end

  initial begin
    step(1, 0, 11'h000, 8'h00, 0, "R9 reset");
    step(1, 0, 11'h000, 8'h00, 0, "R9 reset hold");
    step(0, 0, 11'h000, 8'h00, 0, "R6 plain");
    step(0, 0, 11'h000, 8'h00, 0, "R3 advance");
    step(0, 0, 11'h000, 8'h00, 0, "R3 advance");
    step(0, 1, 11'h2A5, 8'h00, 0, "R1 jump page0");
    step(0, 1, 11'h111, 8'h18, 0, "R7 jump in flushed slot");
    step(0, 0, 11'h000, 8'h00, 0, "R6 plain after flush");
    step(0, 1, 11'h123, 8'h08, 0, "R2 jump page1");
    step(0, 0, 11'h000, 8'h00, 1, "R7 skip in flushed slot");
    step(0, 0, 11'h000, 8'h00, 1, "R5 skip taken");
    step(0, 0, 11'h000, 8'h00, 0, "R5 after skip");
    step(0, 1, 11'h456, 8'hE7, 1, "R8 jump with skip, R10 latch bits");
    step(0, 0, 11'h000, 8'h00, 0, "R4 single flush");
    step(0, 1, 11'h0F0, 8'hF0, 0, "R2 page2 R10");
    step(0, 0, 11'h000, 8'h00, 0, "R4 after jump");
    step(0, 1, 11'h7FF, 8'h18, 0, "R2 page3 top");
    step(0, 0, 11'h000, 8'h00, 0, "R3 wrap to zero");
    step(0, 0, 11'h000, 8'h00, 1, "R5 skip at zero");
    step(0, 0, 11'h000, 8'h00, 1, "R7 skip ignored");
    step(0, 0, 11'h000, 8'h00, 1, "R5 skip again");
    step(1, 1, 11'h3FF, 8'hFF, 1, "R9 reset over requests");
    step(0, 0, 11'h000, 8'h00, 0, "R9 first slot valid");
    step(0, 0, 11'h000, 8'h00, 0, "R6 plain");
    @(negedge clk);
    rst = 0; jump_i = 0; skip_i = 0;
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule